// File: doc/BRIEF.md
# Strobe-Configured Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial receiver and transmitter. Its character format is held in a small format register. The host loads that register by driving a five-bit control word while holding an active-low format strobe low. The word selects 5 to 8 data bits, odd, even or no parity, and one or two stop bits. When two stop bits are chosen with 5-bit characters, the transmitter sends one and a half stop bits instead. Every serial bit time is 16 periods of an oversampling enable, `tick16`, which the block receives from outside. A 960 kHz enable therefore gives 60000 baud, and a 4800 Hz enable gives 300 baud.

The host writes a byte into a transmit holding register with a one-cycle load pulse. The transmitter moves that byte into its shift register on the next oversampling tick on which it is free, and sends it least significant bit first. The receiver finds a start bit on a falling edge and confirms it at mid-bit. It samples each later bit at its centre. When a character completes, it presents the data together with parity-error, framing-error and overrun flags. A two-bit status word is always driven, with no enable. A data-received clear input and a master reset complete the host side. The master reset clears everything except the format register.

Top module: `async_sio`

## Requirements
- R1: While `cfg_strobe_n` is low, the format register follows `cfg_word`. While the strobe is high, changes on `cfg_word` have no effect. The field positions are: bit 4 = parity disable, bit 3 = stop select, bits 2:1 = length code (bit 2 weighs 2, bit 1 weighs 1), bit 0 = parity sense.
- R2: A character has 5 + length code data bits and is sent least significant bit first. Received data is right-aligned in `rx_data`, and the unused upper bits read 0.
- R3: The stop time is 16 ticks when stop select is 0. When stop select is 1 it is 32 ticks, or 24 ticks if the length code is 0. Back-to-back frames start 16·(1 + data bits + parity bits) + stop ticks apart.
- R4: Parity sense 1 makes the count of ones in data plus parity even. Parity sense 0 makes it odd. With parity disable at 1, no parity bit is sent or expected.
- R5: `tx_load` clears the transmit-empty flag on the next clock. The flag sets again on a tick, when the held byte moves into the shifter.
- R6: A low on `rxd` that has ended before the mid-bit confirmation 8 ticks after the falling edge starts no character.
- R7: Data-received sets when a character completes. A one-cycle `rx_clr` clears it, and a completion in the same cycle takes precedence.
- R8: `parity_err` and `framing_err` (first stop bit sampled low) are updated with every received character.
- R9: `overrun` is set when a character completes while data-received is still set, and is cleared by the next completion that finds it clear.
- R10: `mrst` returns the transmitter, receiver and flags to their reset state but keeps the format register.
- R11: `stat_word[1]` is data-received and `stat_word[0]` is transmit-empty. After reset it reads 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the format register too |
| mrst | input | 1 | Synchronous master reset, keeps the format register |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| cfg_strobe_n | input | 1 | Active-low format strobe |
| cfg_word | input | 5 | Format control word |
| tx_load | input | 1 | Load pulse for the transmit holding register |
| tx_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input, asynchronous |
| rx_clr | input | 1 | Clears data-received |
| rx_data | output | 8 | Last received character, right-aligned |
| stat_word | output | 2 | {data-received, transmit-empty} |
| parity_err | output | 1 | Parity error of the last character |
| framing_err | output | 1 | Framing error of the last character |
| overrun | output | 1 | Last character arrived over unread data |

## Verification
The assertions assume four things about the inputs. `tick16` pulses for one clock at a time. `tx_load` and `rx_clr` are single-cycle pulses. The format strobe is used only while both directions are idle. `rxd` holds each bit for a full 16 ticks. The bench meets these as follows. It derives the tick from a fixed clock divider, issues every load and clear as a one-clock pulse from a task, and reprograms the format only after the scoreboard has drained. It drives serial frames on `rxd` with a tick-counted task, or loops `txd` back to `rxd`. The only deliberately short low on `rxd` is the glitch case.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int MAX_BITS = 8;

    // Field order equals the host control word, bit 4 down to bit 0.
    typedef struct packed {
        logic       no_par;
        logic       two_stop;
        logic [1:0] len_sel;
        logic       even_par;
    } fmt_t;

    localparam int FMT_W = $bits(fmt_t);

    // Index of the last data bit: 4..7 for 5..8 bit characters.
    function automatic logic [2:0] last_idx(input logic [1:0] len_sel);
        return 3'd4 + {1'b0, len_sel};
    endfunction

endpackage

// File: rtl/sio_fmt_reg.sv
module sio_fmt_reg
    import sio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_n,
    input  logic [FMT_W-1:0] word,
    output fmt_t             fmt
);
    fmt_t fmt_d, fmt_q;

    always_comb begin
        fmt_d = fmt_q;
        if (!strobe_n) fmt_d = fmt_t'(word);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fmt_q <= '0;
        else        fmt_q <= fmt_d;
    end

    assign fmt = fmt_q;
endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mrst,
    input  logic                tick,
    input  fmt_t                fmt,
    input  logic                load,
    input  logic [MAX_BITS-1:0] din,
    output logic                txd,
    output logic                empty
);
    localparam int CW = $clog2(2 * OSR);
    localparam logic [CW-1:0] BIT_LAST   = CW'(OSR - 1);
    localparam logic [CW-1:0] HALF3_LAST = CW'(OSR + OSR / 2 - 1);
    localparam logic [CW-1:0] TWO_LAST   = CW'(2 * OSR - 1);

    typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tph_e;

    typedef struct packed {
        tph_e                ph;
        logic [CW-1:0]       cnt;
        logic [2:0]          idx;
        logic [MAX_BITS-1:0] hold;
        logic                full;
        logic [MAX_BITS-1:0] sh;
        logic                acc;
        logic                line;
    } tx_s;

    tx_s           s_d, s_q;
    logic [CW-1:0] stop_last;
    logic          take;

    always_comb begin
        s_d  = s_q;
        take = 1'b0;
        if (!fmt.two_stop)            stop_last = BIT_LAST;
        else if (fmt.len_sel == 2'b00) stop_last = HALF3_LAST;
        else                           stop_last = TWO_LAST;

        if (tick) begin
            case (s_q.ph)
                T_IDLE: take = s_q.full;
                T_START: begin
                    if (s_q.cnt == BIT_LAST) begin
                        s_d.ph  = T_DATA;
                        s_d.cnt = '0;
                        s_d.idx = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + CW'(1);
                    end
                end
                T_DATA: begin
                    if (s_q.cnt == BIT_LAST) begin
                        s_d.cnt = '0;
                        s_d.sh  = s_q.sh >> 1;
                        s_d.acc = s_q.acc ^ s_q.sh[0];
                        if (s_q.idx == last_idx(fmt.len_sel))
                            s_d.ph = fmt.no_par ? T_STOP : T_PAR;
                        else
                            s_d.idx = s_q.idx + 3'd1;
                    end else begin
                        s_d.cnt = s_q.cnt + CW'(1);
                    end
                end
                T_PAR: begin
                    if (s_q.cnt == BIT_LAST) begin
                        s_d.cnt = '0;
                        s_d.ph  = T_STOP;
                    end else begin
                        s_d.cnt = s_q.cnt + CW'(1);
                    end
                end
                T_STOP: begin
                    if (s_q.cnt == stop_last) begin
                        take     = s_q.full;
                        s_d.ph   = T_IDLE;
                    end else begin
                        s_d.cnt = s_q.cnt + CW'(1);
                    end
                end
                default: s_d.ph = T_IDLE;
            endcase
        end

        if (take) begin
            s_d.ph   = T_START;
            s_d.cnt  = '0;
            s_d.sh   = s_q.hold;
            s_d.full = 1'b0;
            s_d.acc  = 1'b0;
        end

        if (load) begin
            s_d.hold = din;
            s_d.full = 1'b1;
        end

        case (s_d.ph)
            T_START: s_d.line = 1'b0;
            T_DATA:  s_d.line = s_d.sh[0];
            T_PAR:   s_d.line = fmt.even_par ? s_d.acc : ~s_d.acc;
            default: s_d.line = 1'b1;
        endcase

        if (mrst) begin
            s_d      = '0;
            s_d.line = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.line <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign txd   = s_q.line;
    assign empty = ~s_q.full;
endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mrst,
    input  logic                tick,
    input  logic                no_par,
    input  logic                even_par,
    input  logic [1:0]          len_sel,
    input  logic                rxd,
    input  logic                clr,
    output logic [MAX_BITS-1:0] data,
    output logic                ready,
    output logic                perr,
    output logic                ferr,
    output logic                ovr
);
    localparam int CW = $clog2(2 * OSR);
    localparam logic [CW-1:0] BIT_LAST = CW'(OSR - 1);
    localparam logic [CW-1:0] MID_LAST = CW'(OSR / 2 - 1);

    typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rph_e;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        rph_e                   ph;
        logic [CW-1:0]          cnt;
        logic [2:0]             idx;
        logic [MAX_BITS-1:0]    sh;
        logic                   acc;
        logic                   pe;
        logic [MAX_BITS-1:0]    data;
        logic                   ready;
        logic                   perr;
        logic                   ferr;
        logic                   ovr;
    } rx_s;

    rx_s  s_d, s_q;
    logic line;

    assign line = s_q.sync[SYNC_STAGES-1];

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], rxd};

        if (clr) s_d.ready = 1'b0;

        if (tick) begin
            s_d.prev = line;
            case (s_q.ph)
                R_IDLE: begin
                    if (s_q.prev && !line) begin
                        s_d.ph  = R_START;
                        s_d.cnt = '0;
                        s_d.sh  = '0;
                        s_d.acc = 1'b0;
                        s_d.pe  = 1'b0;
                    end
                end
                R_START: begin
                    if (s_q.cnt == MID_LAST) begin
                        s_d.cnt = '0;
                        s_d.idx = '0;
                        s_d.ph  = line ? R_IDLE : R_DATA;
                    end else begin
                        s_d.cnt = s_q.cnt + CW'(1);
                    end
                end
                R_DATA: begin
                    if (s_q.cnt == BIT_LAST) begin
                        s_d.cnt         = '0;
                        s_d.sh[s_q.idx] = line;
                        s_d.acc         = s_q.acc ^ line;
                        if (s_q.idx == last_idx(len_sel))
                            s_d.ph = no_par ? R_STOP : R_PAR;
                        else
                            s_d.idx = s_q.idx + 3'd1;
                    end else begin
                        s_d.cnt = s_q.cnt + CW'(1);
                    end
                end
                R_PAR: begin
                    if (s_q.cnt == BIT_LAST) begin
                        s_d.cnt = '0;
                        s_d.pe  = even_par ? (s_q.acc ^ line) : ~(s_q.acc ^ line);
                        s_d.ph  = R_STOP;
                    end else begin
                        s_d.cnt = s_q.cnt + CW'(1);
                    end
                end
                R_STOP: begin
                    if (s_q.cnt == BIT_LAST) begin
                        s_d.data  = s_q.sh;
                        s_d.perr  = s_q.pe;
                        s_d.ferr  = ~line;
                        s_d.ovr   = s_q.ready;
                        s_d.ready = 1'b1;
                        s_d.ph    = R_IDLE;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + CW'(1);
                    end
                end
                default: s_d.ph = R_IDLE;
            endcase
        end

        if (mrst) begin
            s_d      = '0;
            s_d.sync = '1;
            s_d.prev = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sync <= '1;
            s_q.prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign data  = s_q.data;
    assign ready = s_q.ready;
    assign perr  = s_q.perr;
    assign ferr  = s_q.ferr;
    assign ovr   = s_q.ovr;
endmodule

// File: rtl/async_sio.sv
module async_sio
    import sio_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mrst,
    input  logic                tick16,
    input  logic                cfg_strobe_n,
    input  logic [FMT_W-1:0]    cfg_word,
    input  logic                tx_load,
    input  logic [MAX_BITS-1:0] tx_data,
    output logic                txd,
    input  logic                rxd,
    input  logic                rx_clr,
    output logic [MAX_BITS-1:0] rx_data,
    output logic [1:0]          stat_word,
    output logic                parity_err,
    output logic                framing_err,
    output logic                overrun
);
    fmt_t fmt;
    logic tx_empty;
    logic rx_ready;

    sio_fmt_reg u_fmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (cfg_strobe_n),
        .word     (cfg_word),
        .fmt      (fmt)
    );

    sio_tx #(.OSR(OSR)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .mrst  (mrst),
        .tick  (tick16),
        .fmt   (fmt),
        .load  (tx_load),
        .din   (tx_data),
        .txd   (txd),
        .empty (tx_empty)
    );

    sio_rx #(.OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .mrst     (mrst),
        .tick     (tick16),
        .no_par   (fmt.no_par),
        .even_par (fmt.even_par),
        .len_sel  (fmt.len_sel),
        .rxd      (rxd),
        .clr      (rx_clr),
        .data     (rx_data),
        .ready    (rx_ready),
        .perr     (parity_err),
        .ferr     (framing_err),
        .ovr      (overrun)
    );

    assign stat_word = {rx_ready, tx_empty};
endmodule

// File: rtl/sio_chk.sv
module sio_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mrst,
    input logic       tick16,
    input logic       tx_load,
    input logic       rx_clr,
    input logic       txd,
    input logic [1:0] stat_word,
    input logic       overrun
);
    // R5
    tbe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_word[0]) |-> $past(tx_load));

    // R5
    tbe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_word[0]) |-> ($past(tick16) || $past(mrst)));

    // R7
    dr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_word[1]) |-> ($past(rx_clr) || $past(mrst)));

    // R9
    ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(stat_word[1]) && stat_word[1]));

    // R10
    mrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |=> (stat_word == 2'b01 && txd && !overrun));
endmodule

bind async_sio sio_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mrst      (mrst),
    .tick16    (tick16),
    .tx_load   (tx_load),
    .rx_clr    (rx_clr),
    .txd       (txd),
    .stat_word (stat_word),
    .overrun   (overrun)
);

// File: tb/sim_async_sio.sv
module sim_async_sio;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mrst = 1'b0;
    logic       tick16 = 1'b0;
    logic       cfg_strobe_n = 1'b1;
    logic [4:0] cfg_word = '0;
    logic       tx_load = 1'b0;
    logic [7:0] tx_data = '0;
    logic       txd;
    logic       rxd;
    logic       rx_clr = 1'b0;
    logic [7:0] rx_data;
    logic [1:0] stat_word;
    logic       parity_err, framing_err, overrun;

    logic loop_en = 1'b1;
    logic bench_rxd = 1'b1;
    assign rxd = loop_en ? txd : bench_rxd;

    async_sio u0 (
        .clk(clk), .rst_n(rst_n), .mrst(mrst), .tick16(tick16),
        .cfg_strobe_n(cfg_strobe_n), .cfg_word(cfg_word),
        .tx_load(tx_load), .tx_data(tx_data), .txd(txd), .rxd(rxd),
        .rx_clr(rx_clr), .rx_data(rx_data), .stat_word(stat_word),
        .parity_err(parity_err), .framing_err(framing_err), .overrun(overrun)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int tdc = 0;
    always @(negedge clk) begin
        if (tdc == TDIV - 1) begin tdc <= 0; tick16 <= 1'b1; end
        else begin tdc <= tdc + 1; tick16 <= 1'b0; end
    end

    int tick_no = 0;
    always @(posedge clk) if (tick16) tick_no <= tick_no + 1;

    logic txd_prev = 1'b1;
    bit   rec_en = 1'b0;
    int   fall_tick[$];
    always @(negedge clk) begin
        if (rec_en && txd_prev && !txd) fall_tick.push_back(tick_no);
        txd_prev <= txd;
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * TDIV) @(negedge clk);
    endtask

    typedef struct {
        logic [7:0] d;
        bit         pe;
        bit         fe;
        bit         ov;
    } exp_t;

    exp_t sb[$];
    bit   mon_hold = 1'b0;
    exp_t got;

    // Monitor: pops the scoreboard whenever a character is reported.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !mon_hold && stat_word[1]) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R7", "unexpected character", int'(rx_data), 0);
                end else begin
                    got = sb.pop_front();
                    check(rx_data == got.d, "R2", "received data", int'(rx_data), int'(got.d));
                    check(parity_err == got.pe, "R8", "parity error flag", int'(parity_err), int'(got.pe));
                    check(framing_err == got.fe, "R8", "framing error flag", int'(framing_err), int'(got.fe));
                    check(overrun == got.ov, "R9", "overrun flag", int'(overrun), int'(got.ov));
                end
                rx_clr = 1'b1;
                @(negedge clk);
                rx_clr = 1'b0;
                check(stat_word[1] == 1'b0, "R7", "data-received after clear", int'(stat_word[1]), 0);
            end
        end
    end

    function automatic logic [7:0] lmask(input logic [4:0] w);
        return 8'hFF >> (3 - int'({w[2], w[1]}));
    endfunction

    logic [4:0] cur_cfg = '0;

    task automatic set_cfg(input logic [4:0] w);
        cfg_word = w; cfg_strobe_n = 1'b0;
        @(negedge clk);
        cfg_strobe_n = 1'b1;
        @(negedge clk);
        cur_cfg = w;
    endtask

    task automatic send_tx(input logic [7:0] d, input bit push, input bit ov);
        if (push) sb.push_back('{d & lmask(cur_cfg), 1'b0, 1'b0, ov});
        while (!stat_word[0]) @(negedge clk);
        tx_data = d; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        wait_ticks(40);
    endtask

    // Two back-to-back frames, distance between start edges in ticks.
    task automatic measure(input logic [7:0] d, input int exp, input string req);
        fall_tick.delete();
        rec_en = 1'b1;
        send_tx(d, 1'b1, 1'b0);
        send_tx(d, 1'b1, 1'b0);
        while (fall_tick.size() < 2) @(negedge clk);
        rec_en = 1'b0;
        check(fall_tick[1] - fall_tick[0] == exp, req, "frame period in ticks",
              fall_tick[1] - fall_tick[0], exp);
        drain();
    endtask

    // Independent line decoder: samples nb bit centres after the start bit.
    task automatic grab(input int nb, output logic [15:0] bits);
        bits = '0;
        while (txd !== 1'b0) @(negedge clk);
        wait_ticks(8);
        for (int i = 0; i < nb; i++) begin
            wait_ticks(16);
            bits[i] = txd;
        end
    endtask

    task automatic send_ser(input logic [7:0] d, input int nb, input bit use_par,
                            input bit even, input bit flip_par, input bit stop_val);
        logic p;
        p = ^(d & (8'hFF >> (8 - nb)));
        p = (even ? p : ~p) ^ flip_par;
        bench_rxd = 1'b0; wait_ticks(16);
        for (int i = 0; i < nb; i++) begin bench_rxd = d[i]; wait_ticks(16); end
        if (use_par) begin bench_rxd = p; wait_ticks(16); end
        bench_rxd = stop_val; wait_ticks(16);
        bench_rxd = 1'b1; wait_ticks(16);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R7 watchdog: actual timeout expected end of run");
        summary();
        $finish;
    end

    logic [15:0] bits;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(stat_word == 2'b01, "R11", "status after reset", int'(stat_word), 1);
        check(txd == 1'b1, "R11", "txd idle after reset", int'(txd), 1);
        check(overrun == 1'b0, "R9", "overrun after reset", int'(overrun), 0);

        // R2 8N1 loopback
        set_cfg(5'h16);
        send_tx(8'hA5, 1'b1, 1'b0);
        send_tx(8'h3C, 1'b1, 1'b0);
        drain();

        // R5 transmit-empty behaviour
        tx_data = 8'h81; tx_load = 1'b1; sb.push_back('{8'h81, 1'b0, 1'b0, 1'b0});
        @(negedge clk);
        tx_load = 1'b0;
        check(stat_word[0] == 1'b0, "R5", "empty after load", int'(stat_word[0]), 0);
        repeat (TDIV + 1) @(negedge clk);
        check(stat_word[0] == 1'b1, "R5", "empty after transfer", int'(stat_word[0]), 1);
        drain();

        // R3 stop lengths and frame periods
        measure(8'hFF, 160, "R3 8N1");
        set_cfg(5'h1E); measure(8'hFF, 176, "R3 8N2");
        set_cfg(5'h18); measure(8'hFF, 120, "R3 5N1.5");
        set_cfg(5'h10); measure(8'hFF, 112, "R3 5N1");
        set_cfg(5'h0D); measure(8'h7F, 176, "R3 7E2");

        // R1 strobe high: word changes ignored
        set_cfg(5'h16);
        cfg_word = 5'h10;
        repeat (5) @(negedge clk);
        measure(8'hFF, 160, "R1 strobe-high word ignored");

        // R4 / R2 line content checked by independent decoder
        set_cfg(5'h05);
        fork
            send_tx(8'h53, 1'b1, 1'b0);
            grab(9, bits);
        join
        check(bits[6:0] == 7'h53, "R2", "lsb-first data on line", int'(bits[6:0]), 'h53);
        check(bits[7] == 1'b0, "R4", "even parity bit", int'(bits[7]), 0);
        check(bits[8] == 1'b1, "R4", "stop after parity", int'(bits[8]), 1);
        drain();
        set_cfg(5'h04);
        fork
            send_tx(8'h53, 1'b1, 1'b0);
            grab(9, bits);
        join
        check(bits[7] == 1'b1, "R4", "odd parity bit", int'(bits[7]), 1);
        drain();
        set_cfg(5'h15);
        fork
            send_tx(8'h53, 1'b1, 1'b0);
            grab(8, bits);
        join
        check(bits[7] == 1'b1, "R4", "no parity bit sent", int'(bits[7]), 1);
        drain();

        // R8 error flags via bench-driven line
        loop_en = 1'b0;
        set_cfg(5'h07);
        sb.push_back('{8'h5A, 1'b1, 1'b0, 1'b0});
        send_ser(8'h5A, 8, 1'b1, 1'b1, 1'b1, 1'b1);
        drain();
        sb.push_back('{8'h5A, 1'b0, 1'b1, 1'b0});
        send_ser(8'h5A, 8, 1'b1, 1'b1, 1'b0, 1'b0);
        drain();
        sb.push_back('{8'h96, 1'b0, 1'b0, 1'b0});
        send_ser(8'h96, 8, 1'b1, 1'b1, 1'b0, 1'b1);
        drain();

        // R6 short glitch rejected
        bench_rxd = 1'b0; wait_ticks(3); bench_rxd = 1'b1;
        wait_ticks(40);
        check(stat_word[1] == 1'b0, "R6", "glitch started a character", int'(stat_word[1]), 0);
        sb.push_back('{8'h6C, 1'b0, 1'b0, 1'b0});
        send_ser(8'h6C, 8, 1'b1, 1'b1, 1'b0, 1'b1);
        drain();

        // R9 overrun
        loop_en = 1'b1;
        set_cfg(5'h16);
        mon_hold = 1'b1;
        send_tx(8'h11, 1'b0, 1'b0);
        send_tx(8'h22, 1'b1, 1'b1);
        while (!stat_word[1]) @(negedge clk);
        check(overrun == 1'b0, "R9", "overrun on first character", int'(overrun), 0);
        check(rx_data == 8'h11, "R7", "first character held", int'(rx_data), 'h11);
        wait_ticks(200);
        check(stat_word == 2'b11, "R11", "status ready and empty", int'(stat_word), 3);
        mon_hold = 1'b0;
        drain();
        send_tx(8'h33, 1'b1, 1'b0);
        drain();

        // R10 master reset keeps format
        send_tx(8'hA5, 1'b0, 1'b0);
        wait_ticks(40);
        mrst = 1'b1;
        @(negedge clk);
        mrst = 1'b0;
        check(stat_word == 2'b01, "R10", "status after master reset", int'(stat_word), 1);
        check(txd == 1'b1, "R10", "txd after master reset", int'(txd), 1);
        wait_ticks(200);
        check(stat_word[1] == 1'b0, "R10", "aborted frame not received", int'(stat_word[1]), 0);
        send_tx(8'hC3, 1'b1, 1'b0);
        drain();

        summary();
        $finish;
    end
endmodule